// File: doc/BRIEF.md
# Critical Temperature Trip Comparator

This block watches several temperature channels and raises an active-low trip output when any channel reads above its own critical limit. Each channel keeps an "over" state that sets when a new reading is strictly above the limit. It clears only once a reading has dropped a fixed hysteresis below that limit, so a fan cannot chatter on and off near the threshold. While the trip is active and the function is enabled, the block also asks the fan PWM and DAC stages to go to full scale.

Readings arrive together for all channels with one valid strobe. Values are 8-bit two's complement degrees Celsius, compared as signed numbers. A summary status bit records that a limit was exceeded, even when the output function is disabled. Each channel also has its own status bit, which records that its over state changed. A change of the trip state produces a single-cycle interrupt request. A monitoring-cycle strobe clears a channel's status bit, but only when that channel's last reading lies inside its normal low/high window.

Top module: `crit_temp_guard`

## Requirements
- R1: A valid reading strictly greater than a channel's critical limit drives `therm_n` low in the cycle after the strobe (enable set). A reading equal to the limit has no effect.
- R2: Once a channel is over, it stays over until a valid reading is at or below its limit minus 5. A reading at limit minus 4 keeps it over.
- R3: `force_full` is high exactly when the trip is active and `therm_en` is high.
- R4: With `therm_en` low, `therm_n` stays high, `force_full` stays low and no interrupt is raised. The over state is still tracked and the summary status still sets, so raising `therm_en` later shows the trip at once.
- R5: A channel's bit in `chan_stat` (bit i = channel i) sets when that channel's over state changes in either direction.
- R6: On `cycle_strobe`, a set `chan_stat` bit clears only if that channel's last valid reading is within [normal low, normal high]. Otherwise it stays set.
- R7: `sum_stat` sets when any channel newly becomes over. On `cycle_strobe` it clears only if no channel is over.
- R8: `int_pulse` is high for exactly one cycle, in the cycle after the strobe that changes the trip state, when `therm_en` is high. With no change there is no pulse.
- R9: Comparisons are signed: with a limit of -20, a reading of -10 trips and a reading of -25 releases.
- R10: After reset, `therm_n` is 1 and `force_full`, `chan_stat`, `sum_stat` and `int_pulse` are 0.
- R11: Each channel is compared only against its own limit. The trip remains active while any channel is over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_valid | input | 1 | New readings present on `temp_in` |
| temp_in | input | N_CH*TEMP_W | Channel readings, channel 0 in the low byte |
| crit_lim | input | N_CH*TEMP_W | Critical trip limits, one per channel |
| norm_hi | input | N_CH*TEMP_W | Normal-window upper limits |
| norm_lo | input | N_CH*TEMP_W | Normal-window lower limits |
| therm_en | input | 1 | Enables the trip pin and the full-scale request |
| cycle_strobe | input | 1 | Start of a monitoring cycle |
| therm_n | output | 1 | Active-low trip output |
| force_full | output | 1 | Request full-scale fan drive |
| chan_stat | output | N_CH | Per-channel trip-change status |
| sum_stat | output | 1 | Limit-exceeded summary status |
| int_pulse | output | 1 | One-cycle interrupt request on trip change |

## Verification
A wrong over state in any channel shows on `therm_n` and `force_full` in the cycle after the offending strobe. It also shows as a missing or extra `int_pulse` in that same cycle. A hysteresis error appears only on a release reading between limit minus 5 and the limit, so the vectors walk those exact values. Status corruption stays hidden until a `cycle_strobe` fails to clear a bit, or clears one it should keep. The bench therefore probes the status right after each strobe, with samples both inside and outside the normal window.

// File: rtl/crit_temp_pkg.sv
package crit_temp_pkg;
  localparam int TEMP_W = 8;
  typedef logic [TEMP_W-1:0] temp_t;

  // strict signed greater-than against the trip limit
  function automatic logic exceeds(input temp_t t, input temp_t lim);
    return $signed(t) > $signed(lim);
  endfunction

  // reading at or below (limit - hyst), evaluated one bit wider to avoid wrap
  function automatic logic released(input temp_t t, input temp_t lim, input int hyst);
    logic signed [TEMP_W:0] floor_v;
    logic signed [TEMP_W:0] t_ext;
    floor_v = $signed({lim[TEMP_W-1], lim}) - $signed((TEMP_W+1)'(hyst));
    t_ext   = $signed({t[TEMP_W-1], t});
    return t_ext <= floor_v;
  endfunction

  // inclusive signed window test
  function automatic logic in_window(input temp_t t, input temp_t lo, input temp_t hi);
    return ($signed(t) >= $signed(lo)) && ($signed(t) <= $signed(hi));
  endfunction
endpackage

// File: rtl/ctg_chan.sv
module ctg_chan
  import crit_temp_pkg::*;
#(
  parameter int HYST = 5
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  temp_valid,
  input  temp_t temp,
  input  temp_t lim,
  input  temp_t hi,
  input  temp_t lo,
  input  logic  cycle_strobe,
  output logic  over_o,
  output logic  over_nxt_o,
  output logic  stat_o
);
  logic  over_q;
  logic  stat_q;
  temp_t sample_q;
  logic  flip;
  logic  clear_ok;

  always_comb begin
    over_nxt_o = over_q;
    if (temp_valid) begin
      if (over_q) over_nxt_o = !released(temp, lim, HYST);
      else        over_nxt_o = exceeds(temp, lim);
    end
  end

  assign flip     = over_nxt_o != over_q;
  assign clear_ok = cycle_strobe && in_window(sample_q, lo, hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      over_q   <= 1'b0;
      stat_q   <= 1'b0;
      sample_q <= '0;
    end else begin
      over_q <= over_nxt_o;
      if (temp_valid) sample_q <= temp;
      if (flip)          stat_q <= 1'b1;
      else if (clear_ok) stat_q <= 1'b0;
    end
  end

  assign over_o = over_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/ctg_summary.sv
module ctg_summary #(
  parameter int N_CH = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] over_cur,
  input  logic [N_CH-1:0] over_nxt,
  input  logic            therm_en,
  input  logic            cycle_strobe,
  output logic            sum_stat,
  output logic            int_pulse
);
  logic new_trip;
  logic trip_edge;

  assign new_trip  = |(over_nxt & ~over_cur);
  assign trip_edge = (|over_nxt) != (|over_cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_stat  <= 1'b0;
      int_pulse <= 1'b0;
    end else begin
      int_pulse <= therm_en & trip_edge;
      if (new_trip)                        sum_stat <= 1'b1;
      else if (cycle_strobe && !(|over_cur)) sum_stat <= 1'b0;
    end
  end
endmodule

// File: rtl/crit_temp_guard.sv
module crit_temp_guard
  import crit_temp_pkg::*;
#(
  parameter int N_CH = 3,
  parameter int HYST = 5,
  localparam int VW  = N_CH * TEMP_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            temp_valid,
  input  logic [VW-1:0]   temp_in,
  input  logic [VW-1:0]   crit_lim,
  input  logic [VW-1:0]   norm_hi,
  input  logic [VW-1:0]   norm_lo,
  input  logic            therm_en,
  input  logic            cycle_strobe,
  output logic            therm_n,
  output logic            force_full,
  output logic [N_CH-1:0] chan_stat,
  output logic            sum_stat,
  output logic            int_pulse
);
  logic [N_CH-1:0] over_cur;
  logic [N_CH-1:0] over_nxt;
  logic            trip_active;

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    ctg_chan #(.HYST(HYST)) u_ch (
      .clk          (clk),
      .rst_n        (rst_n),
      .temp_valid   (temp_valid),
      .temp         (temp_in [i*TEMP_W +: TEMP_W]),
      .lim          (crit_lim[i*TEMP_W +: TEMP_W]),
      .hi           (norm_hi [i*TEMP_W +: TEMP_W]),
      .lo           (norm_lo [i*TEMP_W +: TEMP_W]),
      .cycle_strobe (cycle_strobe),
      .over_o       (over_cur[i]),
      .over_nxt_o   (over_nxt[i]),
      .stat_o       (chan_stat[i])
    );
  end

  ctg_summary #(.N_CH(N_CH)) u_sum (
    .clk          (clk),
    .rst_n        (rst_n),
    .over_cur     (over_cur),
    .over_nxt     (over_nxt),
    .therm_en     (therm_en),
    .cycle_strobe (cycle_strobe),
    .sum_stat     (sum_stat),
    .int_pulse    (int_pulse)
  );

  assign trip_active = |over_cur;
  assign force_full  = trip_active & therm_en;
  assign therm_n     = ~force_full;
endmodule

// File: rtl/ctg_checker.sv
module ctg_checker (
  input logic clk,
  input logic rst_n,
  input logic temp_valid,
  input logic therm_en,
  input logic therm_n,
  input logic force_full,
  input logic int_pulse,
  input logic sum_stat
);
  // R3
  force_tracks_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_full == !therm_n);

  // R4
  disabled_pin_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !therm_en |-> therm_n);

  // R8
  int_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_pulse |=> !int_pulse);

  // R8
  int_needs_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_pulse |-> $past(temp_valid));

  // R1
  pin_holds_without_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(temp_valid) && $stable(therm_en)) |-> $stable(therm_n));

  // R7
  sum_set_by_reading_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sum_stat) |-> $past(temp_valid));
endmodule

bind crit_temp_guard ctg_checker u_ctg_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .temp_valid (temp_valid),
  .therm_en   (therm_en),
  .therm_n    (therm_n),
  .force_full (force_full),
  .int_pulse  (int_pulse),
  .sum_stat   (sum_stat)
);

// File: tb/crit_temp_guard_bench.sv
module crit_temp_guard_bench;
  localparam int N = 3;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           temp_valid = 1'b0;
  logic [N*W-1:0] temp_in = '0;
  logic [N*W-1:0] crit_lim;
  logic [N*W-1:0] norm_hi;
  logic [N*W-1:0] norm_lo;
  logic           therm_en = 1'b1;
  logic           cycle_strobe = 1'b0;
  logic           therm_n;
  logic           force_full;
  logic [N-1:0]   chan_stat;
  logic           sum_stat;
  logic           int_pulse;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  crit_temp_guard u_crit_temp_guard (
    .clk(clk), .rst_n(rst_n), .temp_valid(temp_valid), .temp_in(temp_in),
    .crit_lim(crit_lim), .norm_hi(norm_hi), .norm_lo(norm_lo),
    .therm_en(therm_en), .cycle_strobe(cycle_strobe), .therm_n(therm_n),
    .force_full(force_full), .chan_stat(chan_stat), .sum_stat(sum_stat),
    .int_pulse(int_pulse)
  );

  typedef struct packed {
    logic [7:0] t0;
    logic [7:0] t1;
    logic [7:0] t2;
    logic       exp_n;
    logic       exp_int;
  } vec_t;

  // limits: ch0 80, ch1 90, ch2 70
  localparam vec_t VECS [8] = '{
    '{8'd50, 8'd50, 8'd50, 1'b1, 1'b0},   // R1 idle
    '{8'd80, 8'd50, 8'd50, 1'b1, 1'b0},   // R1 equal, no trip
    '{8'd81, 8'd50, 8'd50, 1'b0, 1'b1},   // R1 trip
    '{8'd76, 8'd50, 8'd50, 1'b0, 1'b0},   // R2 limit-4 holds
    '{8'd75, 8'd50, 8'd50, 1'b1, 1'b1},   // R2 limit-5 releases
    '{8'd50, 8'd91, 8'd50, 1'b0, 1'b1},   // R11 ch1 own limit
    '{8'd50, 8'd85, 8'd71, 1'b0, 1'b0},   // R11 ch1 off, ch2 on
    '{8'd50, 8'd50, 8'd65, 1'b1, 1'b1}    // R11 all released
  };

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  // one valid strobe; returns at the next falling edge, when results are visible
  task automatic feed(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    temp_in    = {c, b, a};
    temp_valid = 1'b1;
    @(negedge clk);
    temp_valid = 1'b0;
  endtask

  task automatic strobe_cycle();
    cycle_strobe = 1'b1;
    @(negedge clk);
    cycle_strobe = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    crit_lim = {8'd70, 8'd90, 8'd80};
    norm_hi  = {8'd60, 8'd60, 8'd60};
    norm_lo  = {8'd0,  8'd0,  8'd0};
    @(negedge clk);
    do_reset();

    // R10 reset state
    chk("R10 therm_n", therm_n, 1);
    chk("R10 force_full", force_full, 0);
    chk("R10 chan_stat", chan_stat, 0);
    chk("R10 sum_stat", sum_stat, 0);
    chk("R10 int_pulse", int_pulse, 0);

    foreach (VECS[i]) begin
      feed(VECS[i].t0, VECS[i].t1, VECS[i].t2);
      chk($sformatf("R1/R2/R11 vec%0d therm_n", i), therm_n, VECS[i].exp_n);
      chk($sformatf("R3 vec%0d force_full", i), force_full, !VECS[i].exp_n);
      chk($sformatf("R8 vec%0d int_pulse", i), int_pulse, VECS[i].exp_int);
      @(negedge clk);
      chk($sformatf("R8 vec%0d pulse gone", i), int_pulse, 0);
    end

    // R5 / R6 / R7 status behaviour
    do_reset();
    feed(8'd81, 8'd10, 8'd10);
    chk("R5 chan_stat after trip", chan_stat, 3'b001);
    chk("R7 sum_stat after trip", sum_stat, 1);
    strobe_cycle();
    chk("R6 kept, sample outside window", chan_stat, 3'b001);
    chk("R7 kept while over", sum_stat, 1);
    feed(8'd50, 8'd10, 8'd10);
    chk("R5 chan_stat after release", chan_stat, 3'b001);
    chk("R1 released pin", therm_n, 1);
    strobe_cycle();
    chk("R6 cleared, sample in window", chan_stat, 3'b000);
    chk("R7 cleared, none over", sum_stat, 0);

    // R4 disabled function
    do_reset();
    therm_en = 1'b0;
    feed(8'd100, 8'd10, 8'd10);
    chk("R4 pin high when disabled", therm_n, 1);
    chk("R4 no force when disabled", force_full, 0);
    chk("R4 no interrupt when disabled", int_pulse, 0);
    chk("R4 summary still set", sum_stat, 1);
    chk("R4 chan_stat still set", chan_stat, 3'b001);
    therm_en = 1'b1;
    #1;
    chk("R4 tracked state shows on enable", therm_n, 0);
    chk("R3 force on enable", force_full, 1);

    // R9 signed comparison
    do_reset();
    crit_lim = {8'd70, 8'd90, 8'hEC};     // ch0 limit -20
    feed(8'hF6, 8'd10, 8'd10);            // -10
    chk("R9 -10 over -20 trips", therm_n, 0);
    feed(8'hE8, 8'd10, 8'd10);            // -24 holds
    chk("R9 -24 holds", therm_n, 0);
    feed(8'hE7, 8'd10, 8'd10);            // -25 releases
    chk("R9 -25 releases", therm_n, 1);
    chk("R8 pulse on signed release", int_pulse, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule